// File: doc/BRIEF.md
# Multilevel Ramp-Read Sense Decoder

This block controls one read of a two-bit-per-cell memory cell in which the cell level is found by timing rather than by parallel comparison. On a start strobe it enables a rising word-line ramp. The ramp is shared by three reference cells with staggered thresholds and by the array cell being read. As the ramp climbs, the reference sense outputs switch on one after another and form a thermometer code. The moment the array cell's sense output switches, the block captures the current reference code. That code then maps to the stored two-bit value.

The read ends when the highest reference fires. The block then pulses a word-line reset for one cycle and presents the decoded value with a one-cycle valid strobe. A read can also abort, raising an error strobe instead of valid. This happens when the reference outputs show a pattern that cannot occur on a rising ramp, or when the top reference does not fire within a programmable number of ramp cycles. The sense-amplifier outputs are asynchronous to the block, so they are brought in through a chain of synchronizing flops.

Top module: `mlc_ramp_reader`

## Requirements
- R1: While reset is held and after its release, rampEn, wlReset, dataValid and readErr are low and readData is 00.
- R2: A startPulse sampled high while idle raises rampEn from the next cycle on. rampEn stays high until the read ends.
- R3: The reference inputs refTrig[2:0] (bit 0 is the lowest threshold, bit 2 the highest) and cellTrig each pass through SYNC_STAGES flops. The reference code held at the first cycle the synchronized cellTrig is high is captured. Later changes of cellTrig during the same read have no effect.
- R4: A captured code decodes as 000 to 11, 001 to 10, 011 to 01 and 111 to 00. A cell that fires together with the top reference reads 00.
- R5: If the top reference fires while the array cell has not fired, the read completes with readData 00 and a dataValid strobe.
- R6: A synchronized top reference with a legal code ends the ramp. In the next cycle wlReset is high for exactly one cycle with rampEn low, and the block then returns to idle.
- R7: dataValid is high for exactly one cycle per successful read. readData changes only in that cycle and holds its value otherwise.
- R8: During the ramp, a synchronized reference code other than 000, 001, 011 or 111 aborts the read. The abort gives a one-cycle readErr together with wlReset, no dataValid, and an unchanged readData.
- R9: The ramp cycles are counted from zero. If the count reaches rampLimit before the top reference is seen, the read aborts with readErr, no dataValid, and an unchanged readData.
- R10: A startPulse during the ramp or during the word-line reset cycle is ignored. No second read follows.
- R11: dataValid and readErr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to begin a read (synchronous) |
| refTrig | input | 3 | Reference sense outputs, bit 0 lowest threshold (asynchronous) |
| cellTrig | input | 1 | Array-cell sense output (asynchronous) |
| rampLimit | input | LIMIT_W | Maximum ramp cycles before abort |
| rampEn | output | 1 | Word-line ramp enable |
| wlReset | output | 1 | One-cycle word-line reset at the end of a read |
| dataValid | output | 1 | One-cycle strobe marking readData as new |
| readData | output | 2 | Decoded two-bit cell value |
| readErr | output | 1 | One-cycle strobe for an aborted read |

## Verification
The bench builds the block with its defaults: an 8-bit ramp limit and two synchronizer stages. This lets a normal ramp limit of 40 cycles sit well above the slowest scripted ramp. A limit of 20 with no reference activity then reaches the timeout path within a short run. Reference edges are placed four cycles apart. This spacing keeps all four decode levels, a cell firing exactly with the lowest reference, and a cell firing exactly with the top reference apart despite the two-cycle synchronizer delay.

// File: rtl/mlcr_pkg.sv
package mlcr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RAMP   = 2'd1,
    ST_FINISH = 2'd2
  } read_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // new read: drop captured code, zero counter
    logic sample;  // ramp cycle: count, capture on first cell trigger
    logic commit;  // successful end: load decoded value
  } ctrl_strb_t;

  localparam int REF_W = 3;

  function automatic logic [1:0] decodeLevel(input logic [REF_W-1:0] code);
    case (code)
      3'b000:  decodeLevel = 2'b11;
      3'b001:  decodeLevel = 2'b10;
      3'b011:  decodeLevel = 2'b01;
      default: decodeLevel = 2'b00;
    endcase
  endfunction

  function automatic logic isThermo(input logic [REF_W-1:0] code);
    isThermo = (code == 3'b000) || (code == 3'b001) ||
               (code == 3'b011) || (code == 3'b111);
  endfunction

endpackage

// File: rtl/mlcr_sync.sv
module mlcr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mlcr_ctrl.sv
module mlcr_ctrl
  import mlcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       topRefSeen,
  input  logic       refLegal,
  input  logic       timeout,
  output ctrl_strb_t strb,
  output logic       rampEn,
  output logic       wlReset,
  output logic       dataValid,
  output logic       readErr
);
  read_state_t stQ, stNxt;
  logic errQ, errNxt;

  always_comb begin
    stNxt  = stQ;
    errNxt = errQ;
    strb   = '0;
    case (stQ)
      ST_IDLE: begin
        if (startPulse) begin
          stNxt      = ST_RAMP;
          strb.clear = 1'b1;
        end
      end
      ST_RAMP: begin
        strb.sample = 1'b1;
        if (!refLegal) begin
          stNxt  = ST_FINISH;
          errNxt = 1'b1;
        end else if (topRefSeen) begin
          stNxt       = ST_FINISH;
          errNxt      = 1'b0;
          strb.commit = 1'b1;
        end else if (timeout) begin
          stNxt  = ST_FINISH;
          errNxt = 1'b1;
        end
      end
      ST_FINISH: stNxt = ST_IDLE;
      default:   stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      errQ <= 1'b0;
    end else begin
      stQ  <= stNxt;
      errQ <= errNxt;
    end
  end

  assign rampEn    = (stQ == ST_RAMP);
  assign wlReset   = (stQ == ST_FINISH);
  assign dataValid = (stQ == ST_FINISH) && !errQ;
  assign readErr   = (stQ == ST_FINISH) && errQ;
endmodule

// File: rtl/mlcr_datapath.sv
module mlcr_datapath
  import mlcr_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strb_t         strb,
  input  logic [REF_W-1:0]   refS,
  input  logic               cellS,
  input  logic [LIMIT_W-1:0] rampLimit,
  output logic               refLegal,
  output logic               timeout,
  output logic [1:0]         readData
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = '1;

  logic [LIMIT_W-1:0] cntQ;
  logic [REF_W-1:0]   codeQ;
  logic               capturedQ;

  assign refLegal = isThermo(refS);
  assign timeout  = (cntQ >= rampLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      codeQ     <= '0;
      capturedQ <= 1'b0;
      readData  <= 2'b00;
    end else begin
      if (strb.clear) begin
        cntQ      <= '0;
        capturedQ <= 1'b0;
      end else if (strb.sample) begin
        if (cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
        if (cellS && !capturedQ) begin
          codeQ     <= refS;
          capturedQ <= 1'b1;
        end
      end
      if (strb.commit)
        readData <= capturedQ ? decodeLevel(codeQ) : 2'b00;
    end
  end
endmodule

// File: rtl/mlc_ramp_reader.sv
module mlc_ramp_reader
  import mlcr_pkg::*;
#(
  parameter int LIMIT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [2:0]         refTrig,
  input  logic               cellTrig,
  input  logic [LIMIT_W-1:0] rampLimit,
  output logic               rampEn,
  output logic               wlReset,
  output logic               dataValid,
  output logic [1:0]         readData,
  output logic               readErr
);
  localparam int SYNC_W = REF_W + 1;

  logic [SYNC_W-1:0] trigS;
  ctrl_strb_t        strb;
  logic              refLegal, timeout;

  mlcr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({cellTrig, refTrig}), .dout(trigS)
  );

  mlcr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .topRefSeen(trigS[REF_W-1]), .refLegal(refLegal), .timeout(timeout),
    .strb(strb), .rampEn(rampEn), .wlReset(wlReset),
    .dataValid(dataValid), .readErr(readErr)
  );

  mlcr_datapath #(.LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .refS(trigS[REF_W-1:0]),
    .cellS(trigS[REF_W]), .rampLimit(rampLimit),
    .refLegal(refLegal), .timeout(timeout), .readData(readData)
  );
endmodule

// File: rtl/mlcr_checker.sv
module mlcr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rampEn,
  input logic       wlReset,
  input logic       dataValid,
  input logic       readErr,
  input logic [1:0] readData
);
  p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  p_data_moves_only_on_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readData) |-> dataValid);

  p_wl_reset_no_ramp_r6: assert property (@(posedge clk) disable iff (!rstN)
    wlReset |-> !rampEn);

  p_wl_reset_after_ramp_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wlReset) |-> $past(rampEn));

  p_wl_reset_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    wlReset |=> !wlReset);

  p_valid_err_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && readErr));

  p_err_ends_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    readErr |-> wlReset);
endmodule

bind mlc_ramp_reader mlcr_checker u_chk (
  .clk(clk), .rstN(rstN), .rampEn(rampEn), .wlReset(wlReset),
  .dataValid(dataValid), .readErr(readErr), .readData(readData)
);

// File: tb/test_mlc_ramp_reader.sv
module test_mlc_ramp_reader;
  localparam int LIMIT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [2:0] refTrig = 3'b000;
  logic cellTrig = 1'b0;
  logic [LIMIT_W-1:0] rampLimit = 8'd40;
  logic rampEn, wlReset, dataValid, readErr;
  logic [1:0] readData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] expD[$];
  bit         expE[$];
  string      expR[$];

  always #10 clk = ~clk;

  mlc_ramp_reader #(.LIMIT_W(LIMIT_W)) i_mlc_ramp_reader (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .refTrig(refTrig),
    .cellTrig(cellTrig), .rampLimit(rampLimit), .rampEn(rampEn),
    .wlReset(wlReset), .dataValid(dataValid), .readData(readData),
    .readErr(readErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prevValid = 1'b0;
  logic [1:0] lastData = 2'b00;
  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid && prevValid) check(1'b0, "R7 valid width", 2, 1);
      if (dataValid || readErr) begin
        if (expD.size() == 0) begin
          check(1'b0, "R10 unexpected result", 1, 0);
        end else begin
          logic [1:0] d;
          bit e;
          string r;
          d = expD.pop_front();
          e = expE.pop_front();
          r = expR.pop_front();
          check(readErr == e, {r, " err"}, readErr, e);
          check(dataValid == !e, {r, " valid"}, dataValid, !e);
          check(readData == (e ? lastData : d), {r, " data"}, readData, e ? lastData : d);
        end
        if (dataValid) lastData = readData;
      end
      prevValid = dataValid;
    end
  end

  // tc/t1/t2/t3: ramp cycle to raise cell/ref1/ref2/ref3, -1 = never
  task automatic doRead(input int tc, input int t1, input int t2, input int t3,
                        input logic [1:0] d, input bit e, input string r,
                        input bit extraStart, input logic [2:0] badCode, input int tBad);
    expD.push_back(d); expE.push_back(e); expR.push_back(r);
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    check(rampEn == 1'b1, "R2 ramp on", rampEn, 1);
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (cyc == tc) cellTrig = 1'b1;
      if (cyc == t1) refTrig[0] = 1'b1;
      if (cyc == t2) refTrig[1] = 1'b1;
      if (cyc == t3) refTrig[2] = 1'b1;
      if (cyc == tBad) refTrig = badCode;
      if (extraStart && cyc == 3) startPulse = 1'b1;
      else startPulse = 1'b0;
      @(negedge clk);
      if (wlReset) begin
        check(rampEn == 1'b0, "R6 ramp off at reset", rampEn, 0);
        break;
      end
      if (cyc > 0 && !rampEn) begin
        check(1'b0, "R2 ramp held", 0, 1);
        break;
      end
    end
    startPulse = extraStart;
    @(negedge clk);
    startPulse = 1'b0;
    check(wlReset == 1'b0, "R6 reset one cycle", wlReset, 0);
    refTrig = 3'b000;
    cellTrig = 1'b0;
    repeat (5) @(negedge clk);
    if (extraStart) check(rampEn == 1'b0, "R10 start ignored", rampEn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rampEn == 0 && wlReset == 0 && dataValid == 0 && readErr == 0,
          "R1 outputs in reset", {rampEn, wlReset, dataValid, readErr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(readData == 2'b00, "R1 data after reset", readData, 0);
    check(rampEn == 0, "R1 ramp idle", rampEn, 0);

    doRead(2,  4, 8, 12, 2'b11, 0, "R4 level 11", 0, 3'b000, -1);
    doRead(6,  4, 8, 12, 2'b10, 0, "R4 level 10", 0, 3'b000, -1);
    doRead(10, 4, 8, 12, 2'b01, 0, "R4 level 01", 0, 3'b000, -1);
    doRead(4,  4, 8, 12, 2'b10, 0, "R3 cell with ref1", 0, 3'b000, -1);
    doRead(12, 4, 8, 12, 2'b00, 0, "R4 cell with ref3", 0, 3'b000, -1);
    doRead(-1, 4, 8, 12, 2'b00, 0, "R5 no cell", 0, 3'b000, -1);
    doRead(2,  4, 8, 12, 2'b11, 0, "R10 start during ramp", 1, 3'b000, -1);
    // R8: illegal pattern 010 after a legal 01 result stays in place
    doRead(10, 4, 8, 12, 2'b01, 0, "R7 set data", 0, 3'b000, -1);
    doRead(1, -1, -1, -1, 2'b00, 1, "R8 illegal code", 0, 3'b010, 3);
    // R9: timeout with no reference activity
    rampLimit = 8'd20;
    doRead(-1, -1, -1, -1, 2'b00, 1, "R9 timeout", 0, 3'b000, -1);
    rampLimit = 8'd40;
    doRead(6,  4, 8, 12, 2'b10, 0, "R9 normal after timeout", 0, 3'b000, -1);

    check(expD.size() == 0, "R7 all results seen", expD.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule